// File: doc/BRIEF.md
# Wake-up frame pattern CRC filter

This block watches a stream of received Ethernet frame bytes and decides, once per frame, whether the frame is a wake-up frame. A byte mask chooses which of the leading frame bytes take part in the decision. Only the chosen bytes are folded, back to back, into a 16-bit CRC. At end of frame the bit-reversed CRC is compared with a stored reference value. This lets one short register set stand in for a long byte pattern, such as an ARP request aimed at a given IPv4 address or an IPv6 neighbour solicitation aimed at a solicited-node multicast group.

Software loads a control word, the reference CRC and the mask words through a plain write port. Received bytes arrive one per cycle, qualified by a valid strobe, with start-of-frame and end-of-frame flags on the first and last bytes. A match can also be made to depend on the destination address being broadcast or multicast. The result is a single-cycle pulse in the cycle after the last byte.

Top module: `wuf_pattern_filter`

## Requirements
- R1: After reset `wake_match` is low, and the filter is disabled until the control word is written.
- R2: Write address 0 is the control word, address 1 is the reference CRC, and the mask words sit at the top of the address space. Address 2^ADDR_W-1 holds the mask for frame bytes 0..15, and each lower address covers the next 16 bytes. Bit j of the word at address 2^ADDR_W-1-w enables frame byte 16*w+j, where byte 0 is the first destination-address byte.
- R3: Only bytes whose mask bit is set enter the CRC, in frame order, with unmasked bytes skipped. The CRC uses the reflected polynomial 0xA001 (0x8005 processed LSB first) and starts from 0xFFFF. Its 16-bit result is bit-reversed and must equal the reference.
- R4: `wake_match` is a one-cycle pulse in the cycle after the byte carrying `rx_eof`, and it is never high at any other time.
- R5: With control bit 15 clear, no frame matches.
- R6: With control bit 8 set, a match also needs destination bytes 0..5 all equal to 0xFF.
- R7: With control bit 9 set, a match also needs bit 0 of destination byte 0 to be set (group address).
- R8: A frame whose length does not reach past the highest enabled mask byte does not match. A frame that ends exactly on that byte may match.
- R9: A wrong CRC gives no match, and bytes beyond the 16*MASK_WORDS mask window never affect the result.
- R10: Cycles with `rx_valid` low change neither the CRC state nor the byte count.
- R11: A byte flagged with `rx_sof` restarts the CRC and byte count, even if the previous frame never ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register write address |
| cfg_wdata | input | 16 | Register write data |
| rx_sof | input | 1 | First byte of frame (with rx_valid) |
| rx_valid | input | 1 | rx_data holds a frame byte |
| rx_eof | input | 1 | Last byte of frame (with rx_valid) |
| rx_data | input | 8 | Frame byte |
| wake_match | output | 1 | One-cycle wake-up match pulse |

## Verification
The bench builds the filter with its default parameters: eight mask words, giving a 128-byte window, and a 4-bit address. This puts every mask address, including the lowest one that covers bytes 112..127, within reach of directed writes. Frames of 200 bytes run past the end of the window, so the saturated byte counter is exercised. The short-frame threshold is tested on both sides of the highest mask bit, at 41/42 bytes for the ARP mask and at 112/113 bytes for the last word.

// File: rtl/wuf_pkg.sv
package wuf_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned EN_BIT = 15;
  localparam int unsigned BC_BIT = 8;
  localparam int unsigned MC_BIT = 9;
  localparam int unsigned DA_LEN = 6;
  localparam logic [15:0] CRC_SEED = 16'hFFFF;
  localparam logic [15:0] CRC_POLY_REFL = 16'hA001;

  // One byte of reflected CRC-16, LSB of the byte first.
  function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c ^ {8'h00, d};
    for (int k = 0; k < 8; k++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
    end
    return r;
  endfunction

  function automatic logic [15:0] rev16(input logic [15:0] v);
    logic [15:0] r;
    for (int k = 0; k < 16; k++) r[k] = v[15-k];
    return r;
  endfunction
endpackage

// File: rtl/wuf_cfg_regs.sv
module wuf_cfg_regs #(
  parameter int unsigned MASK_WORDS = 8,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned NB = MASK_WORDS * wuf_pkg::WORD_W,
  localparam int unsigned CNT_W = $clog2(NB + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  output logic              filt_en,
  output logic              req_bc,
  output logic              req_mc,
  output logic [15:0]       crc_ref,
  output logic [NB-1:0]     mask_bits,
  output logic [CNT_W-1:0]  need_len
);
  import wuf_pkg::*;

  localparam logic [ADDR_W-1:0] CTRL_ADDR = '0;
  localparam logic [ADDR_W-1:0] REF_ADDR  = ADDR_W'(1);
  localparam int unsigned TOP_ADDR = (1 << ADDR_W) - 1;

  logic [2:0]  ctrl_q, ctrl_d;
  logic [15:0] ref_q, ref_d;

  always_comb begin
    ctrl_d = ctrl_q;
    ref_d  = ref_q;
    if (wr_en && wr_addr == CTRL_ADDR)
      ctrl_d = {wr_data[MC_BIT], wr_data[BC_BIT], wr_data[EN_BIT]};
    if (wr_en && wr_addr == REF_ADDR)
      ref_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ref_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      ref_q  <= ref_d;
    end
  end

  assign filt_en = ctrl_q[0];
  assign req_bc  = ctrl_q[1];
  assign req_mc  = ctrl_q[2];
  assign crc_ref = ref_q;

  // Mask word w (frame bytes 16w..16w+15) lives at descending addresses.
  for (genvar w = 0; w < int'(MASK_WORDS); w++) begin : g_mask
    localparam logic [ADDR_W-1:0] WA = ADDR_W'(TOP_ADDR - w);
    logic [WORD_W-1:0] word_q, word_d;
    always_comb word_d = (wr_en && wr_addr == WA) ? wr_data : word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '0;
      else        word_q <= word_d;
    end
    assign mask_bits[w*WORD_W +: WORD_W] = word_q;
  end

  // Frame length needed to reach the highest enabled byte.
  always_comb begin
    need_len = '0;
    for (int b = 0; b < int'(NB); b++) begin
      if (mask_bits[b]) need_len = CNT_W'(b + 1);
    end
  end
endmodule

// File: rtl/wuf_crc_acc.sv
module wuf_crc_acc #(
  parameter int unsigned NB = 128,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_vld,
  input  logic             byte_sof,
  input  logic [7:0]       byte_data,
  input  logic [NB-1:0]    mask_bits,
  output logic [15:0]      crc_now,
  output logic [CNT_W-1:0] len_now,
  output logic [15:0]      crc_q,
  output logic [CNT_W-1:0] cnt_q
);
  import wuf_pkg::*;

  localparam int unsigned IDX_W = $clog2(NB);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NB);

  logic             start, in_win, take;
  logic [CNT_W-1:0] idx, cnt_d;
  logic [15:0]      base, crc_d;

  always_comb begin
    start   = byte_vld && byte_sof;
    idx     = start ? '0 : cnt_q;
    in_win  = idx < LAST;
    take    = byte_vld && in_win && mask_bits[idx[IDX_W-1:0]];
    base    = start ? CRC_SEED : crc_q;
    crc_now = take ? crc_byte(base, byte_data) : base;
    len_now = idx + CNT_W'(1);
    cnt_d   = byte_vld ? (in_win ? idx + CNT_W'(1) : LAST) : cnt_q;
    crc_d   = byte_vld ? crc_now : crc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= CRC_SEED;
      cnt_q <= '0;
    end else begin
      crc_q <= crc_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/wuf_dest_class.sv
module wuf_dest_class #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_vld,
  input  logic             byte_sof,
  input  logic [7:0]       byte_data,
  input  logic [CNT_W-1:0] len_now,
  output logic             is_bcast,
  output logic             is_mcast
);
  import wuf_pkg::*;

  localparam logic [CNT_W-1:0] DA_L = CNT_W'(DA_LEN);

  logic start, bc_now, mc_now, bc_q, mc_q;

  always_comb begin
    start  = byte_vld && byte_sof;
    bc_now = bc_q;
    if (byte_vld && len_now <= DA_L)
      bc_now = (start ? 1'b1 : bc_q) && (byte_data == 8'hFF);
    mc_now   = start ? byte_data[0] : mc_q;
    is_bcast = bc_now && (len_now >= DA_L);
    is_mcast = mc_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bc_q <= 1'b0;
      mc_q <= 1'b0;
    end else begin
      bc_q <= bc_now;
      mc_q <= mc_now;
    end
  end
endmodule

// File: rtl/wuf_pattern_filter.sv
module wuf_pattern_filter #(
  parameter int unsigned MASK_WORDS = 8,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [15:0]       cfg_wdata,
  input  logic              rx_sof,
  input  logic              rx_valid,
  input  logic              rx_eof,
  input  logic [7:0]        rx_data,
  output logic              wake_match
);
  import wuf_pkg::*;

  localparam int unsigned NB = MASK_WORDS * WORD_W;
  localparam int unsigned CNT_W = $clog2(NB + 2);

  logic             filt_en, req_bc, req_mc, is_bcast, is_mcast;
  logic [15:0]      crc_ref, crc_now, crc_q;
  logic [NB-1:0]    mask_bits;
  logic [CNT_W-1:0] need_len, len_now, cnt_q;
  logic             match_d, match_q;

  wuf_cfg_regs #(.MASK_WORDS(MASK_WORDS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_addr(cfg_addr), .wr_data(cfg_wdata),
    .filt_en(filt_en), .req_bc(req_bc), .req_mc(req_mc), .crc_ref(crc_ref),
    .mask_bits(mask_bits), .need_len(need_len)
  );

  wuf_crc_acc #(.NB(NB), .CNT_W(CNT_W)) u_crc (
    .clk(clk), .rst_n(rst_n), .byte_vld(rx_valid), .byte_sof(rx_sof), .byte_data(rx_data),
    .mask_bits(mask_bits), .crc_now(crc_now), .len_now(len_now), .crc_q(crc_q), .cnt_q(cnt_q)
  );

  wuf_dest_class #(.CNT_W(CNT_W)) u_dest (
    .clk(clk), .rst_n(rst_n), .byte_vld(rx_valid), .byte_sof(rx_sof), .byte_data(rx_data),
    .len_now(len_now), .is_bcast(is_bcast), .is_mcast(is_mcast)
  );

  always_comb begin
    match_d = rx_valid && rx_eof && filt_en
           && (len_now >= need_len)
           && (rev16(crc_now) == crc_ref)
           && (!req_bc || is_bcast)
           && (!req_mc || is_mcast);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_q <= 1'b0;
    else        match_q <= match_d;
  end

  assign wake_match = match_q;
endmodule

// File: rtl/wuf_pattern_filter_chk.sv
module wuf_pattern_filter_chk #(
  parameter int unsigned NB = 128,
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_valid,
  input logic             rx_sof,
  input logic             rx_eof,
  input logic             wake_match,
  input logic             filt_en,
  input logic [CNT_W-1:0] need_len,
  input logic [CNT_W-1:0] len_now,
  input logic [CNT_W-1:0] cnt_q,
  input logic [15:0]      crc_q
);
  assert_pulse_at_eof_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wake_match |-> $past(rx_valid && rx_eof));

  assert_enable_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wake_match |-> $past(filt_en));

  assert_length_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_match |-> $past(len_now >= need_len));

  assert_count_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(NB));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> ($stable(crc_q) && $stable(cnt_q)));

  assert_sof_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_sof) |=> (cnt_q == CNT_W'(1)));
endmodule

bind wuf_pattern_filter wuf_pattern_filter_chk #(.NB(NB), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
  .wake_match(wake_match), .filt_en(filt_en), .need_len(need_len), .len_now(len_now),
  .cnt_q(cnt_q), .crc_q(crc_q)
);

// File: tb/wuf_pattern_filter_tb.sv
module wuf_pattern_filter_tb_top;
  logic clk, rst_n, cfg_we, rx_sof, rx_valid, rx_eof, wake_match;
  logic [3:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic [7:0]  rx_data;
  int nchk, nerr;
  bit done;
  logic [15:0] bm [8];

  wuf_pattern_filter dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .rx_sof(rx_sof), .rx_valid(rx_valid), .rx_eof(rx_eof), .rx_data(rx_data),
    .wake_match(wake_match)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic [1:0] kind;
    logic [7:0] len;
    logic       mset;
    logic       en;
    logic       bc;
    logic       mc;
    logic       good;
    logic       gap;
    logic       exp;
    logic [3:0] req;
  } vec_t;

  // kind: 0 ARP request, 1 solicited-node multicast, 2 unicast; mset: 0 ARP mask, 1 NS mask
  localparam vec_t VECS [10] = '{
    '{2'd0, 8'd60,  1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'd6},  // R6 broadcast ARP match
    '{2'd0, 8'd60,  1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 wrong CRC
    '{2'd0, 8'd60,  1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd5},  // R5 disabled
    '{2'd0, 8'd41,  1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd8},  // R8 one byte short
    '{2'd1, 8'd64,  1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'd10}, // R10 gaps, R7 mcast ok
    '{2'd1, 8'd64,  1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd6},  // R6 not broadcast
    '{2'd2, 8'd64,  1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd7},  // R7 unicast rejected
    '{2'd2, 8'd64,  1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'd3},  // R3 plain CRC match
    '{2'd0, 8'd200, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'd9},  // R9 beyond window
    '{2'd0, 8'd42,  1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'd8}   // R8 exact length
  };

  function automatic logic [7:0] fb(input int kind, input int i);
    case (kind)
      0: begin
        if (i < 6) return 8'hFF;
        if (i < 12) return 8'(8'h02 + 8'h11 * (i - 6));
        case (i)
          12: return 8'h08; 13: return 8'h06; 14: return 8'h00; 15: return 8'h01;
          16: return 8'h08; 17: return 8'h00; 18: return 8'h06; 19: return 8'h04;
          20: return 8'h00; 21: return 8'h01;
          38: return 8'hC0; 39: return 8'hA8; 40: return 8'h01; 41: return 8'h0A;
          default: return 8'(i * 7) ^ 8'h5A;
        endcase
      end
      1: begin
        case (i)
          0, 1: return 8'h33; 2: return 8'hFF; 3: return 8'h01; 4: return 8'h02; 5: return 8'h03;
          default: return 8'(i * 3 + 1);
        endcase
      end
      default: return (i == 0) ? 8'h02 : 8'(i * 5);
    endcase
  endfunction

  function automatic logic [15:0] model_crc(input int kind, input int len);
    logic [15:0] c, r;
    c = 16'hFFFF;
    for (int i = 0; i < len && i < 128; i++) begin
      if (bm[i / 16][i % 16]) begin
        c = c ^ {8'h00, fb(kind, i)};
        for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 16'hA001) : (c >> 1);
      end
    end
    for (int k = 0; k < 16; k++) r[k] = c[15-k];
    return r;
  endfunction

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic load_mask();
    for (int w = 0; w < 8; w++) wr(4'(15 - w), bm[w]);
  endtask

  task automatic set_ctrl(input logic en, input logic bc, input logic mc);
    wr(4'd0, {en, 5'd0, mc, bc, 8'd0});
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: wake_match=%0b expected %0b", req, act, exp);
    end
  endtask

  task automatic send(input int kind, input int len, input bit gap, input bit eof,
                      output int early, output logic last, output logic after);
    early = 0;
    last = 1'b0;
    for (int i = 0; i < len; i++) begin
      rx_valid = 1'b1; rx_sof = (i == 0); rx_eof = eof && (i == len - 1);
      rx_data = fb(kind, i);
      @(negedge clk);
      if (i < len - 1 && wake_match) early++;
      last = wake_match;
      if (gap && (i % 3 == 1) && i < len - 1) begin
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
        @(negedge clk);
        if (wake_match) early++;
      end
    end
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
    @(negedge clk);
    after = wake_match;
  endtask

  task automatic run_frame(input string req, input int kind, input int len, input bit gap,
                           input logic exp);
    int early;
    logic last, after;
    send(kind, len, gap, 1'b1, early, last, after);
    chk(req, last, exp);
    chk("R4 early", early != 0, 1'b0);
    chk("R4 single", after, 1'b0);
  endtask

  initial begin
    done = 1'b0;
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog: wake_match=%0b expected progress", wake_match);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    int early;
    logic last, after;
    nchk = 0; nerr = 0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    rx_sof = 1'b0; rx_valid = 1'b0; rx_eof = 1'b0; rx_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset", wake_match, 1'b0);

    // R1: unconfigured filter never matches; only the reference CRC is loaded
    for (int w = 0; w < 8; w++) bm[w] = 16'h0;
    wr(4'd1, model_crc(2, 20));
    run_frame("R1 disabled at reset", 2, 20, 1'b0, 1'b0);

    // Vector table
    for (int v = 0; v < 10; v++) begin
      vec_t t;
      t = VECS[v];
      for (int w = 0; w < 8; w++) bm[w] = 16'h0;
      if (t.mset == 1'b0) begin bm[0] = 16'hF03F; bm[1] = 16'h003F; bm[2] = 16'h03C0; end
      else bm[0] = 16'h003F;
      load_mask();
      set_ctrl(t.en, t.bc, t.mc);
      wr(4'd1, t.good ? model_crc(t.kind, t.len) : (model_crc(t.kind, t.len) ^ 16'h0001));
      run_frame($sformatf("R%0d vector %0d", t.req, v), t.kind, t.len, t.gap, t.exp);
    end

    // R2: lowest mask address covers bytes 112..127; R8 threshold on that word
    for (int w = 0; w < 8; w++) bm[w] = 16'h0;
    bm[7] = 16'h0001;
    load_mask();
    set_ctrl(1'b1, 1'b0, 1'b0);
    wr(4'd1, model_crc(2, 113));
    run_frame("R2 byte 112 mapped to address 8", 2, 113, 1'b0, 1'b1);
    run_frame("R8 frame ends before byte 112", 2, 112, 1'b0, 1'b0);

    // R2: top address bit 5 selects byte 5 (0x03 in kind 1)
    for (int w = 0; w < 8; w++) bm[w] = 16'h0;
    bm[0] = 16'h0020;
    load_mask();
    wr(4'd1, model_crc(1, 30));
    run_frame("R2 byte 5 mapped to address 15", 1, 30, 1'b0, 1'b1);
    wr(4'd1, model_crc(2, 30));
    run_frame("R3 different selected byte", 1, 30, 1'b0, 1'b0);

    // R11: abandoned frame then a fresh start
    for (int w = 0; w < 8; w++) bm[w] = 16'h0;
    bm[0] = 16'hF03F; bm[1] = 16'h003F; bm[2] = 16'h03C0;
    load_mask();
    set_ctrl(1'b1, 1'b1, 1'b0);
    wr(4'd1, model_crc(0, 60));
    send(1, 25, 1'b0, 1'b0, early, last, after);
    chk("R11 no pulse without eof", last | after | (early != 0), 1'b0);
    run_frame("R11 restart on sof", 0, 60, 1'b0, 1'b1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule